// File: doc/BRIEF.md
# Opcode Field Decoder

A purely combinational decoder for one-byte instruction opcodes. The opcode is cut into a 2-bit group and two 3-bit fields. The decoder sorts the byte into an instruction class and hands the execution stage ready-to-use operands:
- destination and source register indices;
- the ALU operation;
- the register-pair selector;
- the branch condition code;
- how many immediate bytes follow the opcode.

The decoder also looks at the zero and carry flags and says whether a relative jump is taken. The prefix byte is flagged so that a later stage can fetch the second opcode byte. Any byte that falls outside the classified space raises an illegal indication.

The block sits between the fetch register and the execute stage. It has no clock or state. Every output is a function of the current opcode and the two flag inputs only.

Top module: `opcode_field_decoder`

## Requirements
- R1: Group is opcode bits 7:6, field Y is bits 5:3 and field Z is bits 2:0. `dst_idx` carries Y for register moves, increments, decrements and byte loads. `src_idx` carries Z for register moves and ALU operations. `alu_op` carries Y for ALU operations. Every one of these outputs is 0 in any other class.
- R2: Group 01 decodes as class 12 (register move), except opcode 0x76, which decodes as class 13 (halt).
- R3: Group 10 decodes as class 14 (ALU on the accumulator).
- R4: In group 00, Z=100 gives class 9 (increment register), Z=101 gives class 10 (decrement register) and Z=110 gives class 11 (load register with byte).
- R5: In group 00, the classes for Z=001 and Z=011 are set by the parity of Y:

  | Z | Y even | Y odd |
  |---|---|---|
  | 001 | class 5 (load pair with word) | class 6 (add pair to HL) |
  | 011 | class 7 (increment pair) | class 8 (decrement pair) |

  For these four classes `pair_sel` = Y[2:1]; in all other classes it is 0.
- R6: The following fixed opcodes have their own classes:

  | Opcode | Class |
  |---|---|
  | 0x00 | class 0 (no-op) |
  | 0x08 | class 1 (store SP to word address) |
  | 0x10 | class 2 (stop) |
  | 0x18 | class 3 (unconditional relative jump) |

- R7: Group 00 with Z=000 and Y in 100..111 decodes as class 4 (conditional relative jump), with `cond_code` = Y[1:0]. The codes are 00 = zero flag clear, 01 = zero flag set, 10 = carry flag clear and 11 = carry flag set. `take_branch` is 1 for class 3. For class 4 it equals the selected test. It is 0 in every other class, and `cond_code` is 0 outside class 4.
- R8: `imm_bytes` is 2 for classes 1 and 5, and 1 for classes 3, 4 and 11. It is 0 for every other class, including stop.
- R9: Opcode 0xCB decodes as class 15 with `is_prefix` = 1 and `illegal` = 0. `is_prefix` is 0 for every other byte.
- R10: Every other opcode decodes as class 31 with `illegal` = 1. In that case `imm_bytes`, `take_branch`, `dst_idx`, `src_idx`, `alu_op`, `pair_sel` and `cond_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Opcode byte to decode |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| op_class | output | 5 | Instruction class code |
| dst_idx | output | 3 | Destination register index |
| src_idx | output | 3 | Source register index |
| alu_op | output | 3 | ALU operation selector |
| pair_sel | output | 2 | Register pair selector |
| cond_code | output | 2 | Jump condition code |
| imm_bytes | output | 2 | Number of immediate bytes following |
| take_branch | output | 1 | Relative jump is taken |
| is_prefix | output | 1 | Opcode is the prefix byte |
| illegal | output | 1 | Opcode is not classified |

## Verification
Two functions can act on the same byte at once: classification and branch evaluation, because a conditional jump must produce a class, an immediate count and a flag-dependent take decision together. The bench provokes this by presenting every opcode under all four zero/carry combinations, one per clock. It judges the class, the offset byte count and the take decision together against a behavioural model. It also checks that flag changes move `take_branch` only for the two jump classes, and that they never alter any field output.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int OPC_W   = 8;
  localparam int GROUP_W = 2;
  localparam int FIELD_W = 3;
  localparam int PAIR_W  = FIELD_W - 1;
  localparam int COND_W  = 2;
  localparam int IMM_W   = 2;
  localparam int CLS_W   = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP       = 5'd0,
    CLS_ST_SP     = 5'd1,
    CLS_STOP      = 5'd2,
    CLS_JR        = 5'd3,
    CLS_JR_COND   = 5'd4,
    CLS_LD_PAIR   = 5'd5,
    CLS_ADD_HL    = 5'd6,
    CLS_INC_PAIR  = 5'd7,
    CLS_DEC_PAIR  = 5'd8,
    CLS_INC_R     = 5'd9,
    CLS_DEC_R     = 5'd10,
    CLS_LD_R_IMM  = 5'd11,
    CLS_MOVE      = 5'd12,
    CLS_HALT      = 5'd13,
    CLS_ALU       = 5'd14,
    CLS_PREFIX    = 5'd15,
    CLS_ILLEGAL   = 5'd31
  } op_class_e;

  // Condition test: bit1 picks the flag (0 zero, 1 carry), bit0 the wanted level.
  function automatic logic cond_holds(input logic [COND_W-1:0] cc,
                                      input logic zf, input logic cf);
    logic sel;
    sel = cc[1] ? cf : zf;
    return sel == cc[0];
  endfunction

  // Immediate byte count per class.
  function automatic logic [IMM_W-1:0] imm_count(input op_class_e cls);
    case (cls)
      CLS_ST_SP, CLS_LD_PAIR:                return IMM_W'(2);
      CLS_JR, CLS_JR_COND, CLS_LD_R_IMM:     return IMM_W'(1);
      default:                               return IMM_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/opdec_fields.sv
module opdec_fields
  import opdec_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  output logic [GROUP_W-1:0] grp,
  output logic [FIELD_W-1:0] fy,
  output logic [FIELD_W-1:0] fz
);
  localparam int Z_LO = 0;
  localparam int Y_LO = Z_LO + FIELD_W;
  localparam int G_LO = Y_LO + FIELD_W;

  assign fz  = opcode[Z_LO +: FIELD_W];
  assign fy  = opcode[Y_LO +: FIELD_W];
  assign grp = opcode[G_LO +: GROUP_W];
endmodule

// File: rtl/opdec_classify.sv
module opdec_classify
  import opdec_pkg::*;
#(
  parameter logic [OPC_W-1:0] PREFIX_CODE = 8'hCB
) (
  input  logic [OPC_W-1:0]   opcode,
  input  logic [GROUP_W-1:0] grp,
  input  logic [FIELD_W-1:0] fy,
  input  logic [FIELD_W-1:0] fz,
  output op_class_e          cls
);
  localparam logic [FIELD_W-1:0] MEM_IDX = FIELD_W'(6);

  logic y_odd;
  logic halt_hit;
  assign y_odd    = fy[0];
  assign halt_hit = (fy == MEM_IDX) && (fz == MEM_IDX);

  always_comb begin
    cls = CLS_ILLEGAL;
    unique case (grp)
      2'b00: begin
        case (fz)
          3'b000: begin
            case (fy)
              3'b000:  cls = CLS_NOP;
              3'b001:  cls = CLS_ST_SP;
              3'b010:  cls = CLS_STOP;
              3'b011:  cls = CLS_JR;
              default: cls = CLS_JR_COND;
            endcase
          end
          3'b001:  cls = y_odd ? CLS_ADD_HL   : CLS_LD_PAIR;
          3'b011:  cls = y_odd ? CLS_DEC_PAIR : CLS_INC_PAIR;
          3'b100:  cls = CLS_INC_R;
          3'b101:  cls = CLS_DEC_R;
          3'b110:  cls = CLS_LD_R_IMM;
          default: cls = CLS_ILLEGAL;
        endcase
      end
      2'b01:   cls = halt_hit ? CLS_HALT : CLS_MOVE;
      2'b10:   cls = CLS_ALU;
      default: cls = (opcode == PREFIX_CODE) ? CLS_PREFIX : CLS_ILLEGAL;
    endcase
  end

  always_comb begin
    // R2
    halt_carve_chk: assert (!(cls == CLS_MOVE && halt_hit))
      else $error("halt slot decoded as move");
  end
endmodule

// File: rtl/opdec_operands.sv
module opdec_operands
  import opdec_pkg::*;
(
  input  op_class_e          cls,
  input  logic [FIELD_W-1:0] fy,
  input  logic [FIELD_W-1:0] fz,
  output logic [FIELD_W-1:0] dst_idx,
  output logic [FIELD_W-1:0] src_idx,
  output logic [FIELD_W-1:0] alu_op,
  output logic [PAIR_W-1:0]  pair_sel,
  output logic [IMM_W-1:0]   imm_bytes
);
  logic uses_dst, uses_src, uses_pair, is_alu;

  assign uses_dst  = (cls == CLS_MOVE) || (cls == CLS_INC_R) ||
                     (cls == CLS_DEC_R) || (cls == CLS_LD_R_IMM);
  assign uses_src  = (cls == CLS_MOVE) || (cls == CLS_ALU);
  assign is_alu    = (cls == CLS_ALU);
  assign uses_pair = (cls == CLS_LD_PAIR) || (cls == CLS_ADD_HL) ||
                     (cls == CLS_INC_PAIR) || (cls == CLS_DEC_PAIR);

  assign dst_idx   = uses_dst  ? fy : '0;
  assign src_idx   = uses_src  ? fz : '0;
  assign alu_op    = is_alu    ? fy : '0;
  assign pair_sel  = uses_pair ? fy[FIELD_W-1:1] : '0;
  assign imm_bytes = imm_count(cls);

  always_comb begin
    // R8
    imm_range_chk: assert (imm_bytes <= IMM_W'(2))
      else $error("immediate count out of range");
    // R5
    pair_only_chk: assert (uses_pair || pair_sel == '0)
      else $error("pair selector outside pair class");
  end
endmodule

// File: rtl/opdec_branch.sv
module opdec_branch
  import opdec_pkg::*;
(
  input  op_class_e          cls,
  input  logic [FIELD_W-1:0] fy,
  input  logic               flag_z,
  input  logic               flag_c,
  output logic [COND_W-1:0]  cond_code,
  output logic               take_branch
);
  logic is_cond, is_always, cond_true;

  assign is_cond     = (cls == CLS_JR_COND);
  assign is_always   = (cls == CLS_JR);
  assign cond_code   = is_cond ? fy[COND_W-1:0] : '0;
  assign cond_true   = cond_holds(fy[COND_W-1:0], flag_z, flag_c);
  assign take_branch = is_always || (is_cond && cond_true);

  always_comb begin
    // R7
    branch_class_chk: assert (!take_branch || is_cond || is_always)
      else $error("branch taken outside jump class");
  end
endmodule

// File: rtl/opcode_field_decoder.sv
module opcode_field_decoder
  import opdec_pkg::*;
#(
  parameter logic [OPC_W-1:0] PREFIX_CODE = 8'hCB
) (
  input  logic [OPC_W-1:0]   opcode,
  input  logic               flag_z,
  input  logic               flag_c,
  output logic [CLS_W-1:0]   op_class,
  output logic [FIELD_W-1:0] dst_idx,
  output logic [FIELD_W-1:0] src_idx,
  output logic [FIELD_W-1:0] alu_op,
  output logic [PAIR_W-1:0]  pair_sel,
  output logic [COND_W-1:0]  cond_code,
  output logic [IMM_W-1:0]   imm_bytes,
  output logic               take_branch,
  output logic               is_prefix,
  output logic               illegal
);
  logic [GROUP_W-1:0] grp;
  logic [FIELD_W-1:0] fy, fz;
  op_class_e          cls;

  opdec_fields u_fields (.opcode(opcode), .grp(grp), .fy(fy), .fz(fz));

  opdec_classify #(.PREFIX_CODE(PREFIX_CODE)) u_classify (
    .opcode(opcode), .grp(grp), .fy(fy), .fz(fz), .cls(cls));

  opdec_operands u_operands (
    .cls(cls), .fy(fy), .fz(fz), .dst_idx(dst_idx), .src_idx(src_idx),
    .alu_op(alu_op), .pair_sel(pair_sel), .imm_bytes(imm_bytes));

  opdec_branch u_branch (
    .cls(cls), .fy(fy), .flag_z(flag_z), .flag_c(flag_c),
    .cond_code(cond_code), .take_branch(take_branch));

  assign op_class  = cls;
  assign illegal   = (cls == CLS_ILLEGAL);
  assign is_prefix = (cls == CLS_PREFIX);

  always_comb begin
    // R10
    illegal_quiet_chk: assert (!illegal ||
      (imm_bytes == '0 && !take_branch && dst_idx == '0 && src_idx == '0 &&
       alu_op == '0 && pair_sel == '0 && cond_code == '0))
      else $error("illegal opcode drives operands");
    // R9
    prefix_exclusive_chk: assert (!is_prefix || (!illegal && opcode == PREFIX_CODE))
      else $error("prefix flag on wrong byte");
  end
endmodule

// File: tb/opcode_field_decoder_bench.sv
`timescale 1ns/1ps
module opcode_field_decoder_bench;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [7:0] opcode;
  logic flag_z, flag_c;
  logic [4:0] op_class;
  logic [2:0] dst_idx, src_idx, alu_op;
  logic [1:0] pair_sel, cond_code, imm_bytes;
  logic take_branch, is_prefix, illegal;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  opcode_field_decoder u_opcode_field_decoder (
    .opcode(opcode), .flag_z(flag_z), .flag_c(flag_c), .op_class(op_class),
    .dst_idx(dst_idx), .src_idx(src_idx), .alu_op(alu_op), .pair_sel(pair_sel),
    .cond_code(cond_code), .imm_bytes(imm_bytes), .take_branch(take_branch),
    .is_prefix(is_prefix), .illegal(illegal));

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s opcode=%02h z=%0d c=%0d actual=%0d expected=%0d",
               tag, what, opcode, flag_z, flag_c, act, exp);
    end
  endtask

  // Behavioural reference built from the requirement text.
  task automatic expect_all(input int op, input int zf, input int cf);
    int x, y, z, cls, dst, src, alu, pr, cc, imm, tk;
    string ctag;
    x = op / 64; y = (op / 8) % 8; z = op % 8;
    cls = 31; dst = 0; src = 0; alu = 0; pr = 0; cc = 0; imm = 0; tk = 0;
    ctag = "R10";
    if (op == 8'hCB) begin cls = 15; ctag = "R9"; end
    else if (x == 1) begin
      ctag = "R2";
      if (op == 8'h76) cls = 13; else begin cls = 12; dst = y; src = z; end
    end else if (x == 2) begin
      ctag = "R3"; cls = 14; src = z; alu = y;
    end else if (x == 0) begin
      if (z == 0 && y < 4) begin ctag = "R6"; cls = y; end
      else if (z == 0) begin
        ctag = "R7"; cls = 4; cc = y - 4;
        case (cc) 0: tk = !zf; 1: tk = zf; 2: tk = !cf; default: tk = cf; endcase
      end else if (z == 1) begin ctag = "R5"; cls = (y % 2) ? 6 : 5; pr = y / 2; end
      else if (z == 3) begin ctag = "R5"; cls = (y % 2) ? 8 : 7; pr = y / 2; end
      else if (z >= 4 && z <= 6) begin ctag = "R4"; cls = 5 + z; dst = y; end
    end
    if (cls == 3) tk = 1;
    if (cls == 1 || cls == 5) imm = 2;
    else if (cls == 3 || cls == 4 || cls == 11) imm = 1;
    check(ctag, "class", op_class, cls);
    check("R1", "dst", dst_idx, dst);
    check("R1", "src", src_idx, src);
    check("R1", "alu", alu_op, alu);
    check("R5", "pair", pair_sel, pr);
    check("R7", "cond", cond_code, cc);
    check("R7", "take", take_branch, tk);
    check("R8", "imm", imm_bytes, imm);
    check("R9", "prefix", is_prefix, (op == 8'hCB) ? 1 : 0);
    check("R10", "illegal", illegal, (cls == 31) ? 1 : 0);
  endtask

  initial begin
    opcode = 8'h00; flag_z = 0; flag_c = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Initial state: opcode 0 is a no-op (R6)
    check("R6", "reset class", op_class, 0);
    check("R10", "reset illegal", illegal, 0);
    // Sweep every opcode under every flag pair, one per clock
    for (int op = 0; op < 256; op++) begin
      for (int f = 0; f < 4; f++) begin
        @(posedge clk);
        opcode = op[7:0]; flag_z = f[0]; flag_c = f[1];
        @(negedge clk);
        expect_all(op, f % 2, f / 2);
      end
    end
    // Targeted corners: halt carve-out, prefix, each condition code
    @(posedge clk); opcode = 8'h76; flag_z = 0; flag_c = 0;
    @(negedge clk); check("R2", "halt class", op_class, 13);
    check("R1", "halt dst", dst_idx, 0);
    @(posedge clk); opcode = 8'h77;
    @(negedge clk); check("R2", "move next to halt", op_class, 12);
    @(posedge clk); opcode = 8'hCB;
    @(negedge clk); check("R9", "prefix", is_prefix, 1);
    @(posedge clk); opcode = 8'h20; flag_z = 1;
    @(negedge clk); check("R7", "NZ with Z set", take_branch, 0);
    @(posedge clk); opcode = 8'h38; flag_c = 1;
    @(negedge clk); check("R7", "C with C set", take_branch, 1);
    @(posedge clk); opcode = 8'hD3;
    @(negedge clk); check("R10", "group 11 illegal", illegal, 1);
    done = 1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
    end
  end

  initial begin
    wait (done || n_fail < 0);
    fork
      wait (done);
      repeat (20001) @(posedge clk);
    join_any
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule